// File: doc/BRIEF.md
# Configurable Logic Element with Look-Up Table, Flip-Flop and Carry

This block is one logic element of a volatile, RAM-configured programmable fabric. A small truth table of 2^K one-bit cells is addressed by the element's K function inputs, and the addressed cell is the function value. Because the table is loaded at run time, the same hardware can realise any Boolean function of its K inputs. A flip-flop samples the table output on every clock. An output selector then picks either the raw table value or that registered copy.

A configuration port with a write strobe, an address and one data bit loads the table one cell at a time. The same port also sets two mode bits. The output-select bit chooses between the combinational and the registered output. The carry-mode bit links the element into an adder chain. In carry mode, function input 2 is replaced by the incoming carry, so a table loaded with three-input parity produces the sum bit. A fixed majority gate forms the outgoing carry. When carry mode is off, the carry passes straight through the element. Nothing survives reset: the table and both mode bits must be reloaded afterwards.

Top module: `cle_elem`

## Requirements
- R1: An active-low reset clears every table cell, the flip-flop, the output-select bit and the carry-mode bit. While reset is held and right after it, elem_out is 0 for any lut_in.
- R2: On a clock edge with cfg_we high and cfg_addr[K] equal to 0, cfg_wdata is stored in the table cell whose index is cfg_addr[K-1:0].
- R3: A table write becomes visible only after the clock edge that performs it. In the cycle of the write, a read of that same cell still returns the old contents.
- R4: With output select 0 (combinational), elem_out equals the table cell indexed by lut_in, where lut_in[0] is the least significant address bit.
- R5: A write of 1 to configuration address 2^K selects the registered output. elem_out then equals the table value that was present at the previous clock edge. A write of 0 to the same address restores the combinational output.
- R6: A write of 1 to configuration address 2^K+1 enables carry mode. In carry mode, carry_in takes the place of lut_in[2] as table address bit 2, so a table holding three-input parity delivers lut_in[0] XOR lut_in[1] XOR carry_in.
- R7: In carry mode, carry_out is the majority of lut_in[0], lut_in[1] and carry_in.
- R8: With carry mode off, carry_out equals carry_in.
- R9: A configuration write to any address from 2^K+2 up changes neither the table nor either mode bit. When cfg_we is low, nothing in the configuration changes.
- R10: With the pattern 0,1,1,0 stored in cells 0 to 3 and the upper inputs at 0, elem_out is the XOR of lut_in[1] and lut_in[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers and the output flip-flop |
| rst_n | input | 1 | Asynchronous active-low reset; clears the whole configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | K+1 | Configuration address: table cells below 2^K, then output select, then carry mode |
| cfg_wdata | input | 1 | Configuration write data bit |
| lut_in | input | K | Function inputs, used as the table read address |
| carry_in | input | 1 | Carry from the neighbouring element below |
| elem_out | output | 1 | Element output, combinational or registered |
| carry_out | output | 1 | Carry to the neighbouring element above |

## Verification
The bench builds the element with its defaults: K of 4, both the flip-flop and the carry variant present. This gives a 16-cell table and a 5-bit configuration address. Random configuration addresses over the full 5-bit range therefore hit table cells, both mode bits and the ignored upper addresses. Random writes often land in the very cell being read, which exercises the old-value-during-write rule. The directed parts load a two-input XOR and a three-input parity with carry mode on. They then sweep all eight combinations of the two addends and the incoming carry, and they assert reset in the middle of the run to confirm that the configuration is lost.

// File: rtl/cle_pkg.sv
package cle_pkg;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_sel_e;

   // majority of three, used for the carry chain
   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/cle_cfg_store.sv
module cle_cfg_store
   import cle_pkg::*;
#(
   parameter int K         = 4,
   parameter bit HAS_FF    = 1'b1,
   parameter bit HAS_CARRY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [K:0]         cfg_addr,
   input  logic               cfg_wdata,
   output logic [(1<<K)-1:0]  table_q,
   output out_sel_e           out_sel,
   output logic               carry_mode
);
   localparam int CELLS = 1 << K;

   logic upper;
   logic sel_hit;
   logic cm_hit;

   assign upper   = cfg_addr[K];
   assign sel_hit = cfg_we && upper && (cfg_addr[K-1:0] == K'(0));
   assign cm_hit  = cfg_we && upper && (cfg_addr[K-1:0] == K'(1));

   generate
      for (genvar c = 0; c < CELLS; c++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               table_q[c] <= 1'b0;
            else if (cfg_we && !upper && (cfg_addr[K-1:0] == K'(c)))
               table_q[c] <= cfg_wdata;
         end
      end

      if (HAS_FF) begin : g_sel_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               out_sel <= OUT_COMB;
            else if (sel_hit)
               out_sel <= cfg_wdata ? OUT_REG : OUT_COMB;
         end
      end else begin : g_sel_fixed
         assign out_sel = OUT_COMB;
      end

      if (HAS_CARRY) begin : g_cm_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               carry_mode <= 1'b0;
            else if (cm_hit)
               carry_mode <= cfg_wdata;
         end
      end else begin : g_cm_fixed
         assign carry_mode = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cle_carry_unit.sv
module cle_carry_unit
   import cle_pkg::*;
#(
   parameter int K         = 4,
   parameter bit HAS_CARRY = 1'b1
) (
   input  logic [K-1:0] lut_in,
   input  logic         carry_in,
   input  logic         carry_mode,
   output logic [K-1:0] lut_addr,
   output logic         carry_out
);
   generate
      if (HAS_CARRY) begin : g_carry
         always_comb begin
            lut_addr = lut_in;
            if (carry_mode)
               lut_addr[2] = carry_in;
         end
         assign carry_out = carry_mode ? maj3(lut_in[0], lut_in[1], carry_in) : carry_in;
      end else begin : g_pass
         assign lut_addr  = lut_in;
         assign carry_out = carry_in;
      end
   endgenerate

endmodule

// File: rtl/cle_lut_read.sv
module cle_lut_read #(
   parameter int K = 4
) (
   input  logic [(1<<K)-1:0] table_q,
   input  logic [K-1:0]      lut_addr,
   output logic              lut_val
);
   localparam int CELLS = 1 << K;

   // binary mux tree, one level per address bit
   logic [2*CELLS-2:0] node;

   generate
      for (genvar c = 0; c < CELLS; c++) begin : g_leaf
         assign node[CELLS-1+c] = table_q[c];
      end
      for (genvar lvl = 0; lvl < K; lvl++) begin : g_lvl
         localparam int BASE = (1 << lvl) - 1;
         localparam int SELB = K - 1 - lvl;
         for (genvar n = 0; n < (1 << lvl); n++) begin : g_node
            assign node[BASE+n] = lut_addr[SELB] ? node[2*(BASE+n)+2] : node[2*(BASE+n)+1];
         end
      end
   endgenerate

   assign lut_val = node[0];

endmodule

// File: rtl/cle_out_stage.sv
module cle_out_stage
   import cle_pkg::*;
#(
   parameter bit HAS_FF = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     lut_val,
   input  out_sel_e out_sel,
   output logic     elem_out
);
   generate
      if (HAS_FF) begin : g_ff
         logic ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ff_q <= 1'b0;
            else
               ff_q <= lut_val;
         end
         assign elem_out = (out_sel == OUT_REG) ? ff_q : lut_val;
      end else begin : g_comb
         assign elem_out = lut_val;
      end
   endgenerate

endmodule

// File: rtl/cle_elem.sv
module cle_elem
   import cle_pkg::*;
#(
   parameter int K         = 4,
   parameter bit HAS_FF    = 1'b1,
   parameter bit HAS_CARRY = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_we,
   input  logic [K:0]   cfg_addr,
   input  logic         cfg_wdata,
   input  logic [K-1:0] lut_in,
   input  logic         carry_in,
   output logic         elem_out,
   output logic         carry_out
);
   localparam int CELLS = 1 << K;

   generate
      if (K < 3 || K > 8) begin : g_bad_k
         $error("cle_elem: K must lie in 3..8");
      end
   endgenerate

   logic [CELLS-1:0] table_q;
   out_sel_e         out_sel;
   logic             carry_mode;
   logic [K-1:0]     lut_addr;
   logic             lut_val;

   cle_cfg_store #(.K(K), .HAS_FF(HAS_FF), .HAS_CARRY(HAS_CARRY)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .table_q   (table_q),
      .out_sel   (out_sel),
      .carry_mode(carry_mode)
   );

   cle_carry_unit #(.K(K), .HAS_CARRY(HAS_CARRY)) i_carry (
      .lut_in    (lut_in),
      .carry_in  (carry_in),
      .carry_mode(carry_mode),
      .lut_addr  (lut_addr),
      .carry_out (carry_out)
   );

   cle_lut_read #(.K(K)) i_read (
      .table_q (table_q),
      .lut_addr(lut_addr),
      .lut_val (lut_val)
   );

   cle_out_stage #(.HAS_FF(HAS_FF)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .lut_val (lut_val),
      .out_sel (out_sel),
      .elem_out(elem_out)
   );

endmodule

// File: rtl/cle_elem_chk.sv
module cle_elem_chk
   import cle_pkg::*;
#(
   parameter int K = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [K:0]        cfg_addr,
   input logic              cfg_wdata,
   input logic [K-1:0]      lut_in,
   input logic              carry_in,
   input logic              elem_out,
   input logic              carry_out,
   input logic [(1<<K)-1:0] table_q,
   input out_sel_e          out_sel,
   input logic              carry_mode,
   input logic              lut_val
);
   localparam int CELLS = 1 << K;

   a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (table_q == '0 && out_sel == OUT_COMB && !carry_mode && !elem_out));

   a_r2_cell_written: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_addr[K]) |=> table_q[$past(cfg_addr[K-1:0])] == $past(cfg_wdata));

   a_r9_idle_keeps_config: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(table_q) && $stable(out_sel) && $stable(carry_mode)));

   a_r9_upper_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr >= (K+1)'(CELLS + 2)) |=>
         ($stable(table_q) && $stable(out_sel) && $stable(carry_mode)));

   a_r5_registered_output: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == OUT_REG) |-> elem_out == $past(lut_val));

   a_r4_comb_output: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == OUT_COMB && !carry_mode) |-> elem_out == table_q[lut_in]);

   a_r7_carry_majority: assert property (@(posedge clk) disable iff (!rst_n)
      carry_mode |-> carry_out == ((lut_in[0] && lut_in[1]) || (carry_in && (lut_in[0] || lut_in[1]))));

   a_r8_carry_passes: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_mode |-> carry_out == carry_in);

endmodule

bind cle_elem cle_elem_chk #(.K(K)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .lut_in    (lut_in),
   .carry_in  (carry_in),
   .elem_out  (elem_out),
   .carry_out (carry_out),
   .table_q   (table_q),
   .out_sel   (out_sel),
   .carry_mode(carry_mode),
   .lut_val   (lut_val)
);

// File: tb/test_cle_elem.sv
module test_cle_elem;
   localparam int K     = 4;
   localparam int CELLS = 1 << K;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [K:0]   cfg_addr = '0;
   logic         cfg_wdata = 1'b0;
   logic [K-1:0] lut_in = '0;
   logic         carry_in = 1'b0;
   logic         elem_out;
   logic         carry_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model of the configuration
   logic [CELLS-1:0] m_tbl = '0;
   logic             m_sel = 1'b0;
   logic             m_cm  = 1'b0;
   logic             m_ff  = 1'b0;

   always #4 clk = ~clk;

   cle_elem #(.K(K)) i_cle_elem (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .lut_in(lut_in), .carry_in(carry_in),
      .elem_out(elem_out), .carry_out(carry_out)
   );

   function automatic logic m_lut();
      logic [K-1:0] a;
      a = lut_in;
      if (m_cm) a[2] = carry_in;
      return m_tbl[a];
   endfunction

   function automatic logic m_out();
      return m_sel ? m_ff : m_lut();
   endfunction

   function automatic logic m_cout();
      if (m_cm)
         return (lut_in[0] & lut_in[1]) | (lut_in[0] & carry_in) | (lut_in[1] & carry_in);
      return carry_in;
   endfunction

   task automatic chk(input logic act, input logic exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic m_reset();
      m_tbl = '0; m_sel = 1'b0; m_cm = 1'b0; m_ff = 1'b0;
   endtask

   task automatic cyc(input bit we, input logic [K:0] a, input bit d,
                      input logic [K-1:0] x, input bit ci, input string tag);
      @(negedge clk);
      cfg_we = we; cfg_addr = a; cfg_wdata = d; lut_in = x; carry_in = ci;
      #1;
      chk(elem_out, m_out(), tag);
      chk(carry_out, m_cout(), m_cm ? "R7" : "R8");
      @(posedge clk);
      m_ff = m_lut();
      if (we) begin
         if (!a[K]) m_tbl[a[K-1:0]] = d;
         else if (a[K-1:0] == 0) m_sel = d;
         else if (a[K-1:0] == 1) m_cm = d;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_we = 1'b0;
      m_reset();
      #1;
      chk(elem_out, 1'b0, "R1");
      @(negedge clk);
      #1;
      chk(elem_out, 1'b0, "R1");
      rst_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R1: after reset every input pattern reads 0
      for (int i = 0; i < CELLS; i++) cyc(0, '0, 0, K'(i), i[0], "R1");
      // R10 / R2: two-input XOR in cells 0..3
      cyc(1, 5'd1, 1, 4'd0, 0, "R2");
      cyc(1, 5'd2, 1, 4'd0, 0, "R2");
      for (int i = 0; i < 4; i++) cyc(0, '0, 0, K'(i), 0, "R10");
      // R3: write to the cell being read, old value first
      cyc(1, 5'd3, 1, 4'd3, 0, "R3");
      cyc(0, '0, 0, 4'd3, 0, "R3");
      cyc(1, 5'd3, 0, 4'd3, 0, "R3");
      cyc(0, '0, 0, 4'd3, 0, "R3");
      // R5: registered output, one cycle behind
      cyc(1, 5'd16, 1, 4'd1, 0, "R5");
      cyc(0, '0, 0, 4'd0, 0, "R5");
      cyc(0, '0, 0, 4'd2, 0, "R5");
      cyc(0, '0, 0, 4'd0, 0, "R5");
      cyc(1, 5'd16, 0, 4'd1, 0, "R5");
      cyc(0, '0, 0, 4'd1, 0, "R4");
      // R9: upper addresses ignored
      for (int a = CELLS + 2; a < 2 * CELLS; a++) cyc(1, 5'(a), 1, 4'd2, 0, "R9");
      cyc(0, '0, 0, 4'd0, 1, "R9");
      cyc(0, '0, 0, 4'd3, 1, "R9");
      // R6 / R7: three-input parity in carry mode
      for (int c = 0; c < CELLS; c++) cyc(1, 5'(c), ^c[2:0], 4'd0, 0, "R2");
      cyc(1, 5'd17, 1, 4'd0, 0, "R6");
      for (int i = 0; i < 8; i++) cyc(0, '0, 0, {2'b00, i[1:0]}, i[2], "R6");
      for (int i = 0; i < 8; i++) cyc(0, '0, 0, {2'b11, i[1:0]}, i[2], "R6");
      // carry mode with registered sum
      cyc(1, 5'd16, 1, 4'd1, 1, "R6");
      for (int i = 0; i < 8; i++) cyc(0, '0, 0, {2'b00, i[1:0]}, i[2], "R5");
      // R1: mid-run reset loses the configuration
      do_reset();
      for (int i = 0; i < CELLS; i++) cyc(0, '0, 0, K'(i), 1, "R1");
      // random mix
      for (int n = 0; n < 600; n++) begin
         bit we;
         logic [K:0] a;
         we = ($urandom_range(0, 9) < 4);
         a  = 5'($urandom_range(0, 2 * CELLS - 1));
         cyc(we, a, 1'($urandom), 4'($urandom), 1'($urandom),
             m_sel ? "R5" : (m_cm ? "R6" : "R4"));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule